// File: doc/BRIEF.md
# Serial Audio Port FIFO and Request Controller

This block is the register and buffering side of a serial audio port. Software, or a DMA engine, writes 32-bit sample words into a transmit FIFO and reads captured words out of a receive FIFO. Both FIFOs are 64 words deep. The serial framer is outside this block. It is represented by one word strobe per direction: on a transmit strobe the framer takes the next word, and on a receive strobe it delivers a captured word. The audio bit clock is represented by a single-cycle tick input, `bclk_tick`, in the system clock domain.

A control/status register holds the following controls: module enable, per-direction run enables, per-direction clear requests, DMA enable, a sync bit and a standby-exit bit. It also reports FIFO occupancy and error flags.

The block waits for the bit clock before some actions take effect:
- A clear request is carried out only on the second bit-clock tick after the write. Each direction has its own sequencer with states XS_IDLE, XS_ARMED and XS_LAST. A request moves it from XS_IDLE or any other state to XS_ARMED. A tick moves XS_ARMED to XS_LAST. A tick in XS_LAST flushes the FIFO and returns the sequencer to XS_IDLE.
- The sync bit is echoed back through a two-stage pipeline clocked by ticks. Software can therefore see that the bit clock runs.
- The port becomes active only after a wake sequencer has counted four ticks. Its states are:
  - WK_OFF, left for WK_WARM when both enable and standby-exit are set.
  - WK_WARM, which counts ticks and goes to WK_ON at the fourth.
  - WK_ON.
  - Dropping either bit returns the sequencer to WK_OFF from any state.

A second register holds four 7-bit levels: transmit request, receive request, transmit panic and receive panic. The DMA request and panic outputs are level comparisons against these values.

Top module: `aud_fifo_ctrl`

Register map (word index on `reg_addr`):
- 0: control/status.
- 1: FIFO port. A write pushes the transmit FIFO and a read pops the receive FIFO.
- 2: levels.
- 3: interrupt enable.
- 4: interrupt status.

Reads are combinational; a FIFO read pops in the cycle `reg_re` is high.

## Requirements
- R1: After reset all control, level and enable fields are 0. The control/status register reads 0x002A0000, which is transmit-needs-data bit 17, transmit-has-room bit 19 and transmit-empty bit 21. `irq`, `dreq_tx`, `dreq_rx`, `panic_tx` and `panic_rx` are low.
- R2: Control bits read back at these positions: enable 0, receive on 1, transmit on 2, DMA enable 9, standby exit 25. The clear bits (transmit 3, receive 4) read as 0.
- R3: Words written to index 1 leave on `tx_word`, in order, one per transmit strobe. `tx_word` is valid from the edge that accepts the strobe. Strobes act only when the port is active and transmit-on is set.
- R4: Words taken on receive strobes (port active, receive-on set) are read from index 1 in arrival order.
- R5: A clear request (bit 3 transmit, bit 4 receive) empties only its own FIFO. This happens on the second `bclk_tick` after the write; after one tick the contents are intact.
- R6: A value written to sync bit 24 reads back only after two `bclk_tick` pulses following the write.
- R7: After enable and standby-exit are set, word strobes are ignored until four `bclk_tick` pulses have been seen.
- R8: A transmit strobe on an empty FIFO sets transmit error (bit 15) and drives `tx_word` to 0. Writing 1 to bit 15 clears it; writing 0 has no effect.
- R9: A receive strobe on a full FIFO (64 words) sets receive error (bit 16) and drops the word. Receive full is status bit 22.
- R10: Transmit request holds while transmit level ≤ level bits 14:8. Transmit panic holds while transmit level ≤ bits 30:24.
- R11: Receive request holds while receive level > level bits 6:0. Receive panic holds while receive level > bits 22:16.
- R12: Receive-has-data is bit 20. Status bits 17 to 22 follow the current FIFO levels.
- R13: `irq` is the OR of enabled interrupt sources: transmit-need 0, receive-need 1, transmit error 2, receive error 3. Writing 1 to bit 2 or bit 3 of index 4 clears that error flag.
- R14: All four request and panic outputs are low unless both DMA enable and module enable are set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bclk_tick | input | 1 | One pulse per audio bit-clock cycle |
| reg_we | input | 1 | Register write strobe |
| reg_re | input | 1 | Register read strobe (pops receive FIFO at index 1) |
| reg_addr | input | 3 | Register word index |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational |
| tx_word_stb | input | 1 | Framer takes a transmit word |
| tx_word | output | 32 | Transmit word last handed to the framer |
| rx_word_stb | input | 1 | Framer delivers a receive word |
| rx_word | input | 32 | Received word |
| dreq_tx | output | 1 | Transmit DMA request |
| dreq_rx | output | 1 | Receive DMA request |
| panic_tx | output | 1 | Transmit panic request |
| panic_rx | output | 1 | Receive panic request |
| irq | output | 1 | Interrupt |

## Verification
A sequencer stuck in or skipping a state shows up at the ports within two ticks. Skipping shows as a FIFO that empties, or a sync echo that flips, one tick early. A stuck sequencer shows as a level that never drops. A wake counter that miscounts lets a receive word into the FIFO after three ticks, which the has-data bit reveals at the next status read. A wrong FIFO pointer or level shows as an out-of-order word on `tx_word` or a wrong request output at the next level boundary. An error flag that fails to latch shows on the status read right after the offending strobe.

// File: rtl/aud_pkg.sv
package aud_pkg;
    localparam int WORD_W = 32;
    localparam int THR_W  = 7;
    localparam int ADDR_W = 3;

    localparam logic [ADDR_W-1:0] A_CS    = 3'd0;
    localparam logic [ADDR_W-1:0] A_FIFO  = 3'd1;
    localparam logic [ADDR_W-1:0] A_LVL   = 3'd2;
    localparam logic [ADDR_W-1:0] A_IEN   = 3'd3;
    localparam logic [ADDR_W-1:0] A_ISTAT = 3'd4;

    // control/status bit positions (software decodes these)
    localparam int B_EN    = 0;
    localparam int B_RXON  = 1;
    localparam int B_TXON  = 2;
    localparam int B_TXCLR = 3;
    localparam int B_RXCLR = 4;
    localparam int B_DMAEN = 9;
    localparam int B_TXERR = 15;
    localparam int B_RXERR = 16;
    localparam int B_TXW   = 17;
    localparam int B_RXR   = 18;
    localparam int B_TXD   = 19;
    localparam int B_RXD   = 20;
    localparam int B_TXE   = 21;
    localparam int B_RXF   = 22;
    localparam int B_SYNC  = 24;
    localparam int B_STBY  = 25;

    // level register field offsets
    localparam int F_RXREQ = 0;
    localparam int F_TXREQ = 8;
    localparam int F_RXPAN = 16;
    localparam int F_TXPAN = 24;

    // interrupt source bits
    localparam int I_TXW   = 0;
    localparam int I_RXR   = 1;
    localparam int I_TXERR = 2;
    localparam int I_RXERR = 3;
    localparam int N_IRQ   = 4;

    typedef enum logic [1:0] {XS_IDLE, XS_ARMED, XS_LAST} xseq_state_t;
    typedef enum logic [1:0] {WK_OFF, WK_WARM, WK_ON} wake_state_t;

    typedef struct packed {
        logic [THR_W-1:0] tx_pan;
        logic [THR_W-1:0] rx_pan;
        logic [THR_W-1:0] tx_req;
        logic [THR_W-1:0] rx_req;
    } lvl_cfg_t;
endpackage

// File: rtl/aud_fifo.sv
module aud_fifo #(
    parameter int W     = 32,
    parameter int DEPTH = 64
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          flush,
    input  logic                          push,
    input  logic [W-1:0]                  wdata,
    input  logic                          pop,
    output logic [W-1:0]                  rdata,
    output logic [$clog2(DEPTH+1)-1:0]    level,
    output logic                          full,
    output logic                          empty
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int LW = $clog2(DEPTH+1);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic [LW-1:0] count;
    logic          do_push, do_pop;

    function automatic logic [AW-1:0] ptr_next(input logic [AW-1:0] p);
        return (p == AW'(DEPTH-1)) ? '0 : p + AW'(1);
    endfunction

    assign full    = (count == LW'(DEPTH));
    assign empty   = (count == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign rdata   = mem[rd_ptr];
    assign level   = count;

    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= ptr_next(wr_ptr);
            if (do_pop)  rd_ptr <= ptr_next(rd_ptr);
            unique case ({do_push, do_pop})
                2'b10:   count <= count + LW'(1);
                2'b01:   count <= count - LW'(1);
                default: count <= count;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (do_push && !flush) mem[wr_ptr] <= wdata;
    end
endmodule

// File: rtl/aud_xdom_seq.sv
// Two-tick delayed action sequencer: a request fires only on the second
// bit-clock tick seen after it; a new request restarts the wait.
module aud_xdom_seq
    import aud_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req,
    input  logic tick,
    output logic fire
);
    xseq_state_t state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= XS_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        if (req) begin
            state_d = XS_ARMED;
        end else begin
            unique case (state_q)
                XS_IDLE:  state_d = XS_IDLE;
                XS_ARMED: if (tick) state_d = XS_LAST;
                XS_LAST:  if (tick) state_d = XS_IDLE;
                default:  state_d = XS_IDLE;
            endcase
        end
    end

    always_comb begin
        fire = 1'b0;
        unique case (state_q)
            XS_LAST: fire = tick && !req;
            default: fire = 1'b0;
        endcase
    end
endmodule

// File: rtl/aud_wake_fsm.sv
module aud_wake_fsm
    import aud_pkg::*;
#(
    parameter int WAKE_TICKS = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic tick,
    output logic active
);
    localparam int CW = $clog2(WAKE_TICKS+1);

    wake_state_t state_q, state_d;
    logic [CW-1:0] cnt_q;
    logic          last_tick;

    assign last_tick = tick && (cnt_q == CW'(WAKE_TICKS-1));

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= WK_OFF;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        if (!enable) begin
            state_d = WK_OFF;
        end else begin
            unique case (state_q)
                WK_OFF:  state_d = WK_WARM;
                WK_WARM: if (last_tick) state_d = WK_ON;
                WK_ON:   state_d = WK_ON;
                default: state_d = WK_OFF;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n || state_q != WK_WARM) cnt_q <= '0;
        else if (tick)                    cnt_q <= cnt_q + CW'(1);
    end

    always_comb begin
        active = 1'b0;
        unique case (state_q)
            WK_ON:   active = enable;
            default: active = 1'b0;
        endcase
    end
endmodule

// File: rtl/aud_fifo_ctrl.sv
module aud_fifo_ctrl
    import aud_pkg::*;
#(
    parameter int DEPTH       = 64,
    parameter int WAKE_TICKS  = 4,
    parameter int ECHO_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bclk_tick,
    input  logic              reg_we,
    input  logic              reg_re,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [WORD_W-1:0] reg_wdata,
    output logic [WORD_W-1:0] reg_rdata,
    input  logic              tx_word_stb,
    output logic [WORD_W-1:0] tx_word,
    input  logic              rx_word_stb,
    input  logic [WORD_W-1:0] rx_word,
    output logic              dreq_tx,
    output logic              dreq_rx,
    output logic              panic_tx,
    output logic              panic_rx,
    output logic              irq
);
    localparam int LVL_W = $clog2(DEPTH+1);
    localparam int N_DIR = 2;   // index 0 transmit, 1 receive

    logic en_q, rx_on, tx_on, dma_en, stby_q, sync_wr, sync_rd;
    logic tx_err, rx_err;
    lvl_cfg_t cfg;
    logic [N_IRQ-1:0] ien;
    logic [ECHO_STAGES-1:0] echo_sr;

    logic wr_cs, wr_fifo, wr_lvl, wr_ien, wr_istat, rd_fifo;
    logic [N_DIR-1:0] clr_req, clr_fire;
    logic tx_flush, rx_flush, port_active;
    logic tx_go, rx_go, tx_underflow, rx_overflow;
    logic [WORD_W-1:0] tx_head, rx_head;
    logic [LVL_W-1:0]  tx_level, rx_level;
    logic tx_full, tx_empty, rx_full, rx_empty;
    logic tx_need, rx_need, dma_live;
    logic [N_IRQ-1:0] istat;
    logic [WORD_W-1:0] cs_view;
    logic unused_wbits;

    assign unused_wbits = ^{reg_wdata[31], reg_wdata[23], reg_wdata[7]};

    // register decode
    assign wr_cs    = reg_we && (reg_addr == A_CS);
    assign wr_fifo  = reg_we && (reg_addr == A_FIFO);
    assign wr_lvl   = reg_we && (reg_addr == A_LVL);
    assign wr_ien   = reg_we && (reg_addr == A_IEN);
    assign wr_istat = reg_we && (reg_addr == A_ISTAT);
    assign rd_fifo  = reg_re && (reg_addr == A_FIFO);

    assign clr_req[0] = wr_cs && reg_wdata[B_TXCLR];
    assign clr_req[1] = wr_cs && reg_wdata[B_RXCLR];

    // control fields
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q    <= 1'b0;
            rx_on   <= 1'b0;
            tx_on   <= 1'b0;
            dma_en  <= 1'b0;
            sync_wr <= 1'b0;
            stby_q  <= 1'b0;
            cfg     <= '0;
            ien     <= '0;
        end else begin
            if (wr_cs) begin
                en_q    <= reg_wdata[B_EN];
                rx_on   <= reg_wdata[B_RXON];
                tx_on   <= reg_wdata[B_TXON];
                dma_en  <= reg_wdata[B_DMAEN];
                sync_wr <= reg_wdata[B_SYNC];
                stby_q  <= reg_wdata[B_STBY];
            end
            if (wr_lvl) begin
                cfg.rx_req <= reg_wdata[F_RXREQ +: THR_W];
                cfg.tx_req <= reg_wdata[F_TXREQ +: THR_W];
                cfg.rx_pan <= reg_wdata[F_RXPAN +: THR_W];
                cfg.tx_pan <= reg_wdata[F_TXPAN +: THR_W];
            end
            if (wr_ien) ien <= reg_wdata[N_IRQ-1:0];
        end
    end

    // sync echo through the bit-clock pipeline
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            echo_sr <= '0;
        end else if (bclk_tick) begin
            echo_sr[0] <= sync_wr;
            for (int i = 1; i < ECHO_STAGES; i++) echo_sr[i] <= echo_sr[i-1];
        end
    end
    assign sync_rd = echo_sr[ECHO_STAGES-1];

    // per-direction clear sequencers
    for (genvar d = 0; d < N_DIR; d++) begin : g_clr
        aud_xdom_seq u_seq (
            .clk  (clk),
            .rst_n(rst_n),
            .req  (clr_req[d]),
            .tick (bclk_tick),
            .fire (clr_fire[d])
        );
    end
    assign tx_flush = clr_fire[0];
    assign rx_flush = clr_fire[1];

    aud_wake_fsm #(.WAKE_TICKS(WAKE_TICKS)) u_wake (
        .clk   (clk),
        .rst_n (rst_n),
        .enable(en_q && stby_q),
        .tick  (bclk_tick),
        .active(port_active)
    );

    assign tx_go        = tx_word_stb && port_active && tx_on;
    assign rx_go        = rx_word_stb && port_active && rx_on;
    assign tx_underflow = tx_go && tx_empty;
    assign rx_overflow  = rx_go && rx_full;

    aud_fifo #(.W(WORD_W), .DEPTH(DEPTH)) u_txq (
        .clk  (clk),
        .rst_n(rst_n),
        .flush(tx_flush),
        .push (wr_fifo),
        .wdata(reg_wdata),
        .pop  (tx_go),
        .rdata(tx_head),
        .level(tx_level),
        .full (tx_full),
        .empty(tx_empty)
    );

    aud_fifo #(.W(WORD_W), .DEPTH(DEPTH)) u_rxq (
        .clk  (clk),
        .rst_n(rst_n),
        .flush(rx_flush),
        .push (rx_go),
        .wdata(rx_word),
        .pop  (rd_fifo),
        .rdata(rx_head),
        .level(rx_level),
        .full (rx_full),
        .empty(rx_empty)
    );

    // word handed to the framer
    always_ff @(posedge clk) begin
        if (!rst_n)            tx_word <= '0;
        else if (tx_underflow) tx_word <= '0;
        else if (tx_go)        tx_word <= tx_head;
    end

    // sticky error flags: setting wins over write-one-to-clear
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_err <= 1'b0;
            rx_err <= 1'b0;
        end else begin
            if (tx_underflow)
                tx_err <= 1'b1;
            else if ((wr_cs && reg_wdata[B_TXERR]) || (wr_istat && reg_wdata[I_TXERR]))
                tx_err <= 1'b0;
            if (rx_overflow)
                rx_err <= 1'b1;
            else if ((wr_cs && reg_wdata[B_RXERR]) || (wr_istat && reg_wdata[I_RXERR]))
                rx_err <= 1'b0;
        end
    end

    // level comparisons and request outputs
    assign tx_need  = tx_level <= LVL_W'(cfg.tx_req);
    assign rx_need  = rx_level >  LVL_W'(cfg.rx_req);
    assign dma_live = dma_en && en_q;
    assign dreq_tx  = dma_live && tx_need;
    assign dreq_rx  = dma_live && rx_need;
    assign panic_tx = dma_live && (tx_level <= LVL_W'(cfg.tx_pan));
    assign panic_rx = dma_live && (rx_level >  LVL_W'(cfg.rx_pan));

    always_comb begin
        istat          = '0;
        istat[I_TXW]   = tx_need;
        istat[I_RXR]   = rx_need;
        istat[I_TXERR] = tx_err;
        istat[I_RXERR] = rx_err;
    end
    assign irq = |(ien & istat);

    always_comb begin
        cs_view          = '0;
        cs_view[B_EN]    = en_q;
        cs_view[B_RXON]  = rx_on;
        cs_view[B_TXON]  = tx_on;
        cs_view[B_DMAEN] = dma_en;
        cs_view[B_TXERR] = tx_err;
        cs_view[B_RXERR] = rx_err;
        cs_view[B_TXW]   = tx_need;
        cs_view[B_RXR]   = rx_need;
        cs_view[B_TXD]   = !tx_full;
        cs_view[B_RXD]   = !rx_empty;
        cs_view[B_TXE]   = tx_empty;
        cs_view[B_RXF]   = rx_full;
        cs_view[B_SYNC]  = sync_rd;
        cs_view[B_STBY]  = stby_q;
    end

    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr)
            A_CS:    reg_rdata = cs_view;
            A_FIFO:  reg_rdata = rx_head;
            A_LVL: begin
                reg_rdata[F_RXREQ +: THR_W] = cfg.rx_req;
                reg_rdata[F_TXREQ +: THR_W] = cfg.tx_req;
                reg_rdata[F_RXPAN +: THR_W] = cfg.rx_pan;
                reg_rdata[F_TXPAN +: THR_W] = cfg.tx_pan;
            end
            A_IEN:   reg_rdata[N_IRQ-1:0] = ien;
            A_ISTAT: reg_rdata[N_IRQ-1:0] = istat;
            default: reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/aud_fifo_ctrl_chk.sv
module aud_fifo_ctrl_chk #(
    parameter int LVL_W = 7,
    parameter int DEPTH = 64
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bclk_tick,
    input logic             tx_word_stb,
    input logic             rx_word_stb,
    input logic             port_active,
    input logic             tx_on,
    input logic             rx_on,
    input logic             tx_empty,
    input logic             rx_full,
    input logic             tx_flush,
    input logic             rx_flush,
    input logic [LVL_W-1:0] tx_level,
    input logic [LVL_W-1:0] rx_level,
    input logic [31:0]      tx_word,
    input logic             sync_rd,
    input logic             tx_err,
    input logic             rx_err
);
    p_tx_flush_empties_r5: assert property (@(posedge clk) disable iff (!rst_n)
        tx_flush |=> (tx_level == '0));

    p_rx_flush_empties_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rx_flush |=> (rx_level == '0));

    p_echo_on_tick_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sync_rd) |-> $past(bclk_tick));

    p_idle_holds_word_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !port_active |=> $stable(tx_word));

    p_underflow_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_word_stb && port_active && tx_on && tx_empty) |=> tx_err);

    p_overflow_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_word_stb && port_active && rx_on && rx_full) |=> rx_err);

    p_level_cap_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (32'(tx_level) <= DEPTH) && (32'(rx_level) <= DEPTH));
endmodule

bind aud_fifo_ctrl aud_fifo_ctrl_chk #(.LVL_W(LVL_W), .DEPTH(DEPTH)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bclk_tick  (bclk_tick),
    .tx_word_stb(tx_word_stb),
    .rx_word_stb(rx_word_stb),
    .port_active(port_active),
    .tx_on      (tx_on),
    .rx_on      (rx_on),
    .tx_empty   (tx_empty),
    .rx_full    (rx_full),
    .tx_flush   (tx_flush),
    .rx_flush   (rx_flush),
    .tx_level   (tx_level),
    .rx_level   (rx_level),
    .tx_word    (tx_word),
    .sync_rd    (sync_rd),
    .tx_err     (tx_err),
    .rx_err     (rx_err)
);

// File: tb/aud_fifo_ctrl_bench.sv
module aud_fifo_ctrl_bench;
    logic        clk, rst_n, bclk_tick, reg_we, reg_re;
    logic [2:0]  reg_addr;
    logic [31:0] reg_wdata, reg_rdata, tx_word, rx_word;
    logic        tx_word_stb, rx_word_stb;
    logic        dreq_tx, dreq_rx, panic_tx, panic_rx, irq;

    int checks = 0;
    int fails  = 0;
    int arm_cnt = 0;
    int done_cnt = 0;
    logic [31:0] exp_q [$];
    logic [31:0] ctrl;
    logic [31:0] v;

    aud_fifo_ctrl u_aud_fifo_ctrl (
        .clk(clk), .rst_n(rst_n), .bclk_tick(bclk_tick),
        .reg_we(reg_we), .reg_re(reg_re), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .tx_word_stb(tx_word_stb), .tx_word(tx_word),
        .rx_word_stb(rx_word_stb), .rx_word(rx_word),
        .dreq_tx(dreq_tx), .dreq_rx(dreq_rx),
        .panic_tx(panic_tx), .panic_rx(panic_rx), .irq(irq)
    );

    initial begin
        clk = 1'b0;
        forever #2 clk = ~clk;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic report();
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(posedge clk); #1;
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk); #1;
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        @(posedge clk); #1;
        reg_re = 1'b1; reg_addr = a;
        @(negedge clk);
        d = reg_rdata;
        @(posedge clk); #1;
        reg_re = 1'b0;
    endtask

    task automatic tick();
        @(posedge clk); #1 bclk_tick = 1'b1;
        @(posedge clk); #1 bclk_tick = 1'b0;
    endtask

    // driver: push a transmit word and record it in the scoreboard
    task automatic tx_push(input logic [31:0] d);
        wr(3'd1, d);
        exp_q.push_back(d);
    endtask

    task automatic tx_pull();
        @(posedge clk); #1 tx_word_stb = 1'b1;
        @(posedge clk); #1 tx_word_stb = 1'b0;
        arm_cnt++;
        @(negedge clk); #1;
    endtask

    task automatic rx_in(input logic [31:0] d);
        @(posedge clk); #1 rx_word_stb = 1'b1; rx_word = d;
        @(posedge clk); #1 rx_word_stb = 1'b0;
    endtask

    // monitor: compare each word the design hands out against the scoreboard
    always @(negedge clk) begin
        if (done_cnt < arm_cnt) begin
            done_cnt++;
            if (exp_q.size() == 0) chk("R3 scoreboard empty", tx_word, 32'hX);
            else                   chk("R3 tx order", tx_word, exp_q.pop_front());
        end
    end

    initial begin
        #(4 * 150000);
        fails++;
        $display("FAIL watchdog expired");
        report();
    end

    initial begin
        rst_n = 0; bclk_tick = 0; reg_we = 0; reg_re = 0; reg_addr = 0;
        reg_wdata = 0; tx_word_stb = 0; rx_word_stb = 0; rx_word = 0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1;

        // R1 reset state
        rd(3'd0, v);
        chk("R1 cs reset", v, 32'h002A0000);
        chk("R1 outputs low", {27'd0, dreq_tx, dreq_rx, panic_tx, panic_rx, irq}, 32'd0);

        // R2 control readback
        ctrl = 32'h02000207;
        wr(3'd0, ctrl | 32'h18);
        rd(3'd0, v);
        chk("R2 cs readback", v, 32'h022A0207);

        // R7 wake needs four ticks
        rx_in(32'h11);
        rd(3'd0, v);
        chk("R7 ignored before ticks", v & 32'h00110000, 32'd0);
        tick(); tick(); tick();
        rx_in(32'h22);
        rd(3'd0, v);
        chk("R7 ignored after three ticks", v & 32'h00110000, 32'd0);
        tick();
        rx_in(32'h33);
        rd(3'd0, v);
        chk("R12 rx has data", v & 32'h00100000, 32'h00100000);
        rd(3'd1, v);
        chk("R7 first accepted word", v, 32'h33);

        // R3 transmit order via scoreboard
        tx_push(32'hCAFE0001);
        tx_push(32'hCAFE0002);
        tx_push(32'hCAFE0003);
        tx_pull(); tx_pull(); tx_pull();

        // R8 underflow
        @(posedge clk); #1 tx_word_stb = 1'b1;
        @(posedge clk); #1 tx_word_stb = 1'b0;
        @(negedge clk);
        chk("R8 underflow word", tx_word, 32'd0);
        rd(3'd0, v);
        chk("R8 txerr set", v & 32'h8000, 32'h8000);
        wr(3'd0, ctrl);
        rd(3'd0, v);
        chk("R8 write 0 keeps txerr", v & 32'h8000, 32'h8000);
        wr(3'd0, ctrl | 32'h8000);
        rd(3'd0, v);
        chk("R8 write 1 clears txerr", v & 32'h8000, 32'd0);

        // R4 receive order
        rx_in(32'hBEEF0001);
        rx_in(32'hBEEF0002);
        rd(3'd1, v); chk("R4 rx word 0", v, 32'hBEEF0001);
        rd(3'd1, v); chk("R4 rx word 1", v, 32'hBEEF0002);

        // R10/R11 thresholds: rx req 2, tx req 3, rx panic 5, tx panic 1
        wr(3'd2, 32'h01050302);
        @(negedge clk);
        chk("R10 empty tx req/panic", {30'd0, dreq_tx, panic_tx}, 32'd3);
        wr(3'd1, 32'h1); wr(3'd1, 32'h2);
        @(negedge clk);
        chk("R10 tx level 2", {30'd0, dreq_tx, panic_tx}, 32'd2);
        wr(3'd1, 32'h3); wr(3'd1, 32'h4);
        @(negedge clk);
        chk("R10 tx level 4", {30'd0, dreq_tx, panic_tx}, 32'd0);
        rx_in(1); rx_in(2);
        @(negedge clk);
        chk("R11 rx level 2", {30'd0, dreq_rx, panic_rx}, 32'd0);
        rx_in(3);
        @(negedge clk);
        chk("R11 rx level 3", {30'd0, dreq_rx, panic_rx}, 32'd2);
        rx_in(4); rx_in(5); rx_in(6);
        @(negedge clk);
        chk("R11 rx level 6", {30'd0, dreq_rx, panic_rx}, 32'd3);

        // R14 gating by DMA enable
        wr(3'd0, ctrl & ~32'h200);
        @(negedge clk);
        chk("R14 gated", {28'd0, dreq_tx, dreq_rx, panic_tx, panic_rx}, 32'd0);
        wr(3'd0, ctrl);
        @(negedge clk);
        chk("R14 ungated", {31'd0, dreq_rx}, 32'd1);

        // R5 transmit clear after two ticks, receive untouched
        wr(3'd0, ctrl | 32'h8);
        rd(3'd0, v);
        chk("R5 tx kept at write", v & 32'h00200000, 32'd0);
        tick();
        rd(3'd0, v);
        chk("R5 tx kept after one tick", v & 32'h00200000, 32'd0);
        tick();
        rd(3'd0, v);
        chk("R5 tx empty after two ticks, rx kept", v & 32'h00300000, 32'h00300000);
        wr(3'd0, ctrl | 32'h10);
        tick(); tick();
        rd(3'd0, v);
        chk("R5 rx cleared", v & 32'h00100000, 32'd0);

        // R6 sync echo
        ctrl = ctrl | 32'h01000000;
        wr(3'd0, ctrl);
        rd(3'd0, v);
        chk("R6 sync before ticks", v & 32'h01000000, 32'd0);
        tick();
        rd(3'd0, v);
        chk("R6 sync after one tick", v & 32'h01000000, 32'd0);
        tick();
        rd(3'd0, v);
        chk("R6 sync after two ticks", v & 32'h01000000, 32'h01000000);

        // R9 overflow
        for (int i = 0; i < 64; i++) rx_in(32'hA0000000 + i);
        rd(3'd0, v);
        chk("R9 full no error", v & 32'h00410000, 32'h00400000);
        rx_in(32'hDEADDEAD);
        rd(3'd0, v);
        chk("R9 overflow error", v & 32'h00010000, 32'h00010000);

        // R13 interrupt on receive error
        wr(3'd3, 32'h8);
        @(negedge clk);
        chk("R13 irq raised", {31'd0, irq}, 32'd1);
        rd(3'd4, v);
        chk("R13 status bit", v & 32'h8, 32'h8);
        wr(3'd4, 32'h8);
        @(negedge clk);
        chk("R13 irq cleared", {31'd0, irq}, 32'd0);

        for (int i = 0; i < 64; i++) begin
            rd(3'd1, v);
            chk("R9 stored word", v, 32'hA0000000 + i);
        end
        rd(3'd0, v);
        chk("R9 dropped word absent", v & 32'h00100000, 32'd0);

        repeat (4) @(posedge clk);
        if (exp_q.size() != 0) chk("R3 scoreboard drained", exp_q.size(), 0);
        report();
    end
endmodule